// File: doc/BRIEF.md
# Supply Reset Pulse Generator

This block drives one active-high reset line for downstream logic from three digital sources. The first is a supply-good level from an external comparator. The second is a manual reset request. The third is an internal programmable hold-off timer. The reset line is high whenever the supply is reported bad or the manual request is high. Once every cause has gone away, the line stays high for one of four selectable timeout lengths and then drops. Any new cause that appears while the timeout is running starts the count again from zero.

Two auxiliary comparator levels are routed straight to monitor outputs with no register in the path. A synchronised copy of each level is also captured into a two-bit status word that a host can read at any time. The comparators and their trip levels are outside the block, so every input arrives as a plain digital level. Each input is asynchronous to the system clock and is resynchronised by two flops before it reaches any logic. The only exception is the straight monitor path.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_ok_i` is low, `rst_o` is high. When `supply_ok_i` falls while the block is idle, `rst_o` is still low after the second rising edge that follows the change and is high after the third.
- R2: When `supply_ok_i` rises and no other cause is present, `rst_o` stays high and falls at the (T+2)-th rising edge after the change, where T is the selected timeout count.
- R3: A high `man_rst_i` forces `rst_o` high. After `man_rst_i` returns low, `rst_o` falls at the (T+2)-th rising edge.
- R4: `tmo_sel_i` picks T as follows: 2'b00 selects TMO_0, 2'b01 selects TMO_1, 2'b10 selects TMO_2 and 2'b11 selects TMO_3.
- R5: `mon_a_o` equals `mon_a_i` and `mon_b_o` equals `mon_b_i` at all times, with no clocked delay.
- R6: `mon_stat_o[0]` holds the state of `mon_a_i` and `mon_stat_o[1]` holds the state of `mon_b_i`. A change on either input appears in the status word from the third rising edge after it and not before.
- R7: A cause that appears while the timeout is running restarts the count. `rst_o` then falls at the (T+2)-th rising edge after that later cause is removed.
- R8: While `rst_n` is low, `rst_o` is high and `mon_stat_o` is 2'b00. After `rst_n` rises with the supply good, `rst_o` falls at the (T+2)-th rising edge.
- R9: When the supply is bad and the manual request is high at the same time, `rst_o` stays high until both are removed. The timeout is counted from the later removal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok_i | input | 1 | Supply-good comparator level, asynchronous (1 = above threshold) |
| man_rst_i | input | 1 | Manual reset request, asynchronous, active high |
| mon_a_i | input | 1 | Auxiliary comparator A level, asynchronous |
| mon_b_i | input | 1 | Auxiliary comparator B level, asynchronous |
| tmo_sel_i | input | 2 | Timeout selector |
| rst_o | output | 1 | Combined reset output, active high |
| mon_a_o | output | 1 | Direct copy of comparator A |
| mon_b_o | output | 1 | Direct copy of comparator B |
| mon_stat_o | output | 2 | Captured monitor status for the host (bit 0 = A, bit 1 = B) |

## Verification
Supply recovery and manual-reset release can both act on the same hold-off counter. Two cases cover this.

In the first case, both causes are applied on the same clock. The supply recovers while the manual request is still held, and the request is dropped well after a full timeout would have expired. `rst_o` must stay high for the whole time, and the measured low-going edge must sit exactly T+2 edges after the manual release.

In the second case, a single-cycle manual pulse lands in the middle of a running supply timeout. The count must be judged from the pulse's end, not from the supply's return.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic [1:0] {
        TMO_SEL_0 = 2'b00,
        TMO_SEL_1 = 2'b01,
        TMO_SEL_2 = 2'b10,
        TMO_SEL_3 = 2'b11
    } tmo_sel_e;

    // Raw asynchronous inputs grouped for the synchroniser.
    typedef struct packed {
        logic supply_ok;
        logic man_rst;
        logic mon_b;
        logic mon_a;
    } async_in_t;

    localparam int unsigned ASYNC_W = $bits(async_in_t);

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/srg_sync2.sv
module srg_sync2 #(
    parameter int unsigned W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/srg_holdoff.sv
module srg_holdoff
    import srg_pkg::*;
#(
    parameter int unsigned TMO_0 = 12,
    parameter int unsigned TMO_1 = 25,
    parameter int unsigned TMO_2 = 50,
    parameter int unsigned TMO_3 = 75,
    parameter int unsigned CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cause_i,
    input  logic [1:0] sel_i,
    output logic       busy_o
);

    localparam logic [CNT_W-1:0] LIM_0   = CNT_W'(TMO_0);
    localparam logic [CNT_W-1:0] LIM_1   = CNT_W'(TMO_1);
    localparam logic [CNT_W-1:0] LIM_2   = CNT_W'(TMO_2);
    localparam logic [CNT_W-1:0] LIM_3   = CNT_W'(TMO_3);
    localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(max4(TMO_0, TMO_1, TMO_2, TMO_3));

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } hold_st_t;

    hold_st_t         st_d, st_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        case (tmo_sel_e'(sel_i))
            TMO_SEL_0: lim = LIM_0;
            TMO_SEL_1: lim = LIM_1;
            TMO_SEL_2: lim = LIM_2;
            default:   lim = LIM_3;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (cause_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt >= lim - CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

    // R1 / R3: any active cause holds the output on the next cycle.
    p_cause_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cause_i |=> st_q.busy);

    // R7: the output only drops in a cycle with no cause present.
    p_fall_needs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(!cause_i));

    // R2: once idle, the output stays low until a cause appears.
    p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !cause_i) |=> !st_q.busy);

    // R4: the count never passes the largest selectable limit.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < LIM_MAX);

endmodule

// File: rtl/srg_mon_capture.sv
module srg_mon_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mon_sync_i,
    output logic [1:0] stat_o
);

    logic [1:0] stat_d, stat_q;

    always_comb begin
        stat_d = mon_sync_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 2'b00;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

    // R6: the status word follows the synchronised monitors one cycle later.
    p_stat_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q == $past(mon_sync_i));

endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
    import srg_pkg::*;
#(
    parameter int unsigned TMO_0 = 5_000_000,
    parameter int unsigned TMO_1 = 10_000_000,
    parameter int unsigned TMO_2 = 20_000_000,
    parameter int unsigned TMO_3 = 30_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok_i,
    input  logic       man_rst_i,
    input  logic       mon_a_i,
    input  logic       mon_b_i,
    input  logic [1:0] tmo_sel_i,
    output logic       rst_o,
    output logic       mon_a_o,
    output logic       mon_b_o,
    output logic [1:0] mon_stat_o
);

    localparam int unsigned TMO_MAX = max4(TMO_0, TMO_1, TMO_2, TMO_3);
    localparam int unsigned CNT_W   = $clog2(TMO_MAX + 1);

    async_in_t raw_in, sync_in;
    logic      cause;

    always_comb begin
        raw_in.supply_ok = supply_ok_i;
        raw_in.man_rst   = man_rst_i;
        raw_in.mon_b     = mon_b_i;
        raw_in.mon_a     = mon_a_i;
    end

    srg_sync2 #(
        .W       (ASYNC_W),
        .RST_VAL ('0)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign cause = !sync_in.supply_ok || sync_in.man_rst;

    srg_holdoff #(
        .TMO_0 (TMO_0),
        .TMO_1 (TMO_1),
        .TMO_2 (TMO_2),
        .TMO_3 (TMO_3),
        .CNT_W (CNT_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .sel_i   (tmo_sel_i),
        .busy_o  (rst_o)
    );

    srg_mon_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_sync_i ({sync_in.mon_b, sync_in.mon_a}),
        .stat_o     (mon_stat_o)
    );

    // R5: monitor outputs are straight wires with no register.
    assign mon_a_o = mon_a_i;
    assign mon_b_o = mon_b_i;

    // R3: a synchronised manual request drives the reset output next cycle.
    p_man_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in.man_rst |=> rst_o);

    // R1: a synchronised bad supply drives the reset output next cycle.
    p_low_supply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_in.supply_ok |=> rst_o);

endmodule

// File: tb/supply_reset_gen_tb_top.sv
module supply_reset_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T0 = 12;
    localparam int T1 = 25;
    localparam int T2 = 50;
    localparam int T3 = 75;

    // Vector: {sel[1:0], kind} with kind 0 = supply drop, 1 = manual reset.
    localparam int NVEC = 8;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b00_0, 3'b01_1, 3'b10_0, 3'b11_1,
        3'b00_1, 3'b01_0, 3'b10_1, 3'b11_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b1;
    logic       man_rst = 1'b0;
    logic       mon_a = 1'b0;
    logic       mon_b = 1'b0;
    logic [1:0] tmo_sel = 2'b00;
    logic       rst_out;
    logic       mon_a_out;
    logic       mon_b_out;
    logic [1:0] mon_stat;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supply_reset_gen #(
        .TMO_0 (T0), .TMO_1 (T1), .TMO_2 (T2), .TMO_3 (T3)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok),
        .man_rst_i   (man_rst),
        .mon_a_i     (mon_a),
        .mon_b_i     (mon_b),
        .tmo_sel_i   (tmo_sel),
        .rst_o       (rst_out),
        .mon_a_o     (mon_a_out),
        .mon_b_o     (mon_b_out),
        .mon_stat_o  (mon_stat)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'b00:   return T0;
            2'b01:   return T1;
            2'b10:   return T2;
            default: return T3;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count rising edges after the last input change until rst_out reads low.
    task automatic measure(input int exp, input string tag);
        int n = 0;
        while (n < exp + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!rst_out) break;
        end
        check(n == exp, tag, n, exp);
    endtask

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        cycles(3);
        check(rst_out == 1'b1, "R8 rst_o in reset", rst_out, 1);
        check(mon_stat == 2'b00, "R8 status in reset", mon_stat, 0);
        rst_n = 1'b1;
        measure(T0 + 2, "R8 power-up timeout");

        // Table walk: R1 / R3 hold, R2 / R3 / R4 timeout length.
        for (int i = 0; i < NVEC; i++) begin
            tmo_sel = VEC[i][2:1];
            if (VEC[i][0]) man_rst = 1'b1;
            else           supply_ok = 1'b0;
            cycles(T3 / 2);
            check(rst_out == 1'b1, VEC[i][0] ? "R3 manual holds" : "R1 low supply holds",
                  rst_out, 1);
            if (VEC[i][0]) man_rst = 1'b0;
            else           supply_ok = 1'b1;
            measure(lim_of(VEC[i][2:1]) + 2,
                    VEC[i][0] ? "R3 R4 manual timeout" : "R2 R4 supply timeout");
        end

        // R1: latency of a supply drop from idle.
        tmo_sel = 2'b00;
        cycles(2);
        supply_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(rst_out == 1'b0, "R1 still low after second edge", rst_out, 0);
        @(posedge clk); @(negedge clk);
        check(rst_out == 1'b1, "R1 high after third edge", rst_out, 1);
        supply_ok = 1'b1;
        measure(T0 + 2, "R2 recovery after latency test");

        // R5: direct monitor path.
        mon_a = 1'b1;
        #1;
        check(mon_a_out == 1'b1 && mon_b_out == 1'b0, "R5 pass-through A",
              {mon_b_out, mon_a_out}, 1);
        // R6: status capture timing.
        @(posedge clk); @(negedge clk);
        check(mon_stat == 2'b00, "R6 status after first edge", mon_stat, 0);
        @(posedge clk); @(negedge clk);
        check(mon_stat == 2'b00, "R6 status after second edge", mon_stat, 0);
        @(posedge clk); @(negedge clk);
        check(mon_stat == 2'b01, "R6 status after third edge", mon_stat, 1);
        mon_a = 1'b0;
        mon_b = 1'b1;
        #1;
        check(mon_a_out == 1'b0 && mon_b_out == 1'b1, "R5 pass-through B",
              {mon_b_out, mon_a_out}, 2);
        cycles(3);
        check(mon_stat == 2'b10, "R6 status B", mon_stat, 2);
        check(rst_out == 1'b0, "R6 monitors leave reset alone", rst_out, 0);

        // R7: restart by a manual pulse inside a running timeout.
        tmo_sel = 2'b01;
        supply_ok = 1'b0;
        cycles(5);
        supply_ok = 1'b1;
        cycles(12);
        check(rst_out == 1'b1, "R7 mid-timeout high", rst_out, 1);
        man_rst = 1'b1;
        @(negedge clk);
        man_rst = 1'b0;
        measure(T1 + 2, "R7 restart from pulse end");

        // R9: both causes together; later release governs.
        tmo_sel = 2'b00;
        supply_ok = 1'b0;
        man_rst = 1'b1;
        cycles(5);
        supply_ok = 1'b1;
        cycles(T0 * 3);
        check(rst_out == 1'b1, "R9 held while manual remains", rst_out, 1);
        man_rst = 1'b0;
        measure(T0 + 2, "R9 timeout from later release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule